// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and mode flags of an 8-bit accumulator-style CPU core. From bit 7 down to bit 0 the flags are N (negative), V (overflow), T (memory-operation mode), B (break), D (decimal), I (interrupt disable), Z (zero) and C (carry). The core asserts `done_i` on the cycle in which an instruction completes. With it, the core presents a small class code that says which flags that instruction may touch, the candidate N, V, Z and C values from its ALU, and a byte from the data bus. On the next rising clock edge the register applies the class rule to each bit. Under that rule a bit takes the ALU candidate, is forced to a fixed value, is loaded from the bus, or keeps its value.

T works as a one-instruction mode bit. Every completing instruction clears it, except the set-T class, which sets it, and the full-load class, which takes it from the bus. The full-load class is used when the status byte is restored from the stack. There is no state machine: the single register state is the flag byte itself. The transition on each completion is chosen by the class code, and in every cycle without a completion the state holds.

Top module: `psr_unit`

## Requirements
- R1: While `rst_n` is low, `flags_o` is 8'h04: I set, every other bit, T and D included, cleared.
- R2: In a cycle where `done_i` is low, `flags_o` keeps its value whatever the class, ALU and bus inputs are.
- R3: Class 0 (other instructions) changes no flag except clearing T (bit 5). Every completing class other than 13 and 14 also leaves T at 0.
- R4: Class 13 (set T) sets T to 1 and leaves the other seven bits unchanged.
- R5: Class 1 (add/subtract with carry) loads N, V, Z and C from `alu_nvzc_i`, whose bits 3..0 are N, V, Z, C. B, D and I are kept.
- R6: Class 2 (bit test family) loads N, V and Z from the ALU and keeps C, B, D and I.
- R7: Class 3 (shift right) forces N to 0, loads Z and C from the ALU and keeps V, B, D and I.
- R8: Class 4 (compare) loads N, Z and C from the ALU and keeps V, B, D and I.
- R9: Class 5 (loads, transfers, increments, decrements, logic ops) loads only N and Z from the ALU.
- R10: Classes 6..12 force a single bit and keep the rest apart from T: 6 clears C, 7 sets C, 8 clears D, 9 sets D, 10 clears I, 11 sets I, 12 clears V.
- R11: Class 14 (full load) copies all eight bits of `bus_i` into the register, T included, and ignores the ALU inputs.
- R12: Class 15, which has no assigned meaning, changes nothing except clearing T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| done_i | input | 1 | An instruction completes in this cycle |
| cls_i | input | 4 | Flag-update class of the completing instruction |
| alu_nvzc_i | input | 4 | ALU candidate flags, bits 3..0 = N, V, Z, C |
| bus_i | input | 8 | Status byte from the data bus for the full-load class |
| flags_o | output | 8 | Current flags, bit 7..0 = N, V, T, B, D, I, Z, C |

## Verification
An update that is presented with `done_i` is visible on `flags_o` exactly one rising edge later, because only one register lies between the inputs and the output. The reset value is visible on the first edge at which `rst_n` is sampled low. The bench drives inputs on the falling edge, waits for one rising edge and samples on the next falling edge, so each result is read half a cycle after it settles. Before each table vector, a full-load step puts a known byte in the register, so every kept bit has a value that can be seen at the output.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int FLAG_W  = 8;
    localparam int CLS_W   = 4;
    localparam int ALU_W   = 4;

    localparam int BIT_N = 7;
    localparam int BIT_V = 6;
    localparam int BIT_T = 5;
    localparam int BIT_B = 4;
    localparam int BIT_D = 3;
    localparam int BIT_I = 2;
    localparam int BIT_Z = 1;
    localparam int BIT_C = 0;

    localparam logic [FLAG_W-1:0] FLAGS_RESET = 8'h04;

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER  = 4'd0,
        CLS_ARITH  = 4'd1,
        CLS_BTEST  = 4'd2,
        CLS_SHR    = 4'd3,
        CLS_CMP    = 4'd4,
        CLS_NZ     = 4'd5,
        CLS_CLR_C  = 4'd6,
        CLS_SET_C  = 4'd7,
        CLS_CLR_D  = 4'd8,
        CLS_SET_D  = 4'd9,
        CLS_CLR_I  = 4'd10,
        CLS_SET_I  = 4'd11,
        CLS_CLR_V  = 4'd12,
        CLS_SET_T  = 4'd13,
        CLS_LOAD   = 4'd14
    } psr_class_e;

    typedef struct packed {
        logic [FLAG_W-1:0] take_alu;
        logic [FLAG_W-1:0] force_en;
        logic [FLAG_W-1:0] force_val;
        logic              take_bus;
    } psr_rule_t;

endpackage

// File: rtl/psr_rule_decode.sv
module psr_rule_decode
    import psr_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output psr_rule_t        rule_o
);

    psr_class_e cls;
    assign cls = psr_class_e'(cls_i);

    always_comb begin
        rule_o           = '0;
        rule_o.force_en  = '0;
        rule_o.force_en[BIT_T] = 1'b1;
        unique case (cls)
            CLS_OTHER: ;
            CLS_ARITH: begin
                rule_o.take_alu[BIT_N] = 1'b1;
                rule_o.take_alu[BIT_V] = 1'b1;
                rule_o.take_alu[BIT_Z] = 1'b1;
                rule_o.take_alu[BIT_C] = 1'b1;
            end
            CLS_BTEST: begin
                rule_o.take_alu[BIT_N] = 1'b1;
                rule_o.take_alu[BIT_V] = 1'b1;
                rule_o.take_alu[BIT_Z] = 1'b1;
            end
            CLS_SHR: begin
                rule_o.force_en[BIT_N] = 1'b1;
                rule_o.take_alu[BIT_Z] = 1'b1;
                rule_o.take_alu[BIT_C] = 1'b1;
            end
            CLS_CMP: begin
                rule_o.take_alu[BIT_N] = 1'b1;
                rule_o.take_alu[BIT_Z] = 1'b1;
                rule_o.take_alu[BIT_C] = 1'b1;
            end
            CLS_NZ: begin
                rule_o.take_alu[BIT_N] = 1'b1;
                rule_o.take_alu[BIT_Z] = 1'b1;
            end
            CLS_CLR_C: rule_o.force_en[BIT_C] = 1'b1;
            CLS_SET_C: begin
                rule_o.force_en[BIT_C]  = 1'b1;
                rule_o.force_val[BIT_C] = 1'b1;
            end
            CLS_CLR_D: rule_o.force_en[BIT_D] = 1'b1;
            CLS_SET_D: begin
                rule_o.force_en[BIT_D]  = 1'b1;
                rule_o.force_val[BIT_D] = 1'b1;
            end
            CLS_CLR_I: rule_o.force_en[BIT_I] = 1'b1;
            CLS_SET_I: begin
                rule_o.force_en[BIT_I]  = 1'b1;
                rule_o.force_val[BIT_I] = 1'b1;
            end
            CLS_CLR_V: rule_o.force_en[BIT_V] = 1'b1;
            CLS_SET_T: rule_o.force_val[BIT_T] = 1'b1;
            CLS_LOAD: begin
                rule_o.force_en = '0;
                rule_o.take_bus = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/psr_next_calc.sv
module psr_next_calc
    import psr_pkg::*;
(
    input  psr_rule_t         rule_i,
    input  logic [FLAG_W-1:0] cur_i,
    input  logic [ALU_W-1:0]  alu_nvzc_i,
    input  logic [FLAG_W-1:0] bus_i,
    output logic [FLAG_W-1:0] nxt_o
);

    logic [FLAG_W-1:0] alu_vec;

    always_comb begin
        alu_vec        = '0;
        alu_vec[BIT_N] = alu_nvzc_i[3];
        alu_vec[BIT_V] = alu_nvzc_i[2];
        alu_vec[BIT_Z] = alu_nvzc_i[1];
        alu_vec[BIT_C] = alu_nvzc_i[0];
    end

    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        always_comb begin
            if (rule_i.take_bus)
                nxt_o[b] = bus_i[b];
            else if (rule_i.force_en[b])
                nxt_o[b] = rule_i.force_val[b];
            else if (rule_i.take_alu[b])
                nxt_o[b] = alu_vec[b];
            else
                nxt_o[b] = cur_i[b];
        end
    end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [ALU_W-1:0]  alu_nvzc_i,
    input  logic [FLAG_W-1:0] bus_i,
    output logic [FLAG_W-1:0] flags_o
);

    psr_rule_t         rule;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_nxt;

    psr_rule_decode u_decode (
        .cls_i  (cls_i),
        .rule_o (rule)
    );

    psr_next_calc u_calc (
        .rule_i     (rule),
        .cur_i      (flags_q),
        .alu_nvzc_i (alu_nvzc_i),
        .bus_i      (bus_i),
        .nxt_o      (flags_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= FLAGS_RESET;
        else if (done_i)
            flags_q <= flags_nxt;
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk
    import psr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              done_i,
    input logic [CLS_W-1:0]  cls_i,
    input logic [ALU_W-1:0]  alu_nvzc_i,
    input logic [FLAG_W-1:0] bus_i,
    input logic [FLAG_W-1:0] flags_o
);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> flags_o == $past(flags_o));

    // R3
    t_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i != 4'd13 && cls_i != 4'd14) |=> !flags_o[BIT_T]);

    // R4
    t_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == 4'd13) |=> flags_o == ($past(flags_o) | 8'h20));

    // R5
    arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == 4'd1) |=>
            {flags_o[7:6], flags_o[1:0]} == $past(alu_nvzc_i));

    // R6
    btest_keep_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == 4'd2) |=> flags_o[BIT_C] == $past(flags_o[BIT_C]));

    // R7
    shr_n_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == 4'd3) |=> !flags_o[BIT_N]);

    // R8
    cmp_keep_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == 4'd4) |=> flags_o[BIT_V] == $past(flags_o[BIT_V]));

    // R11
    full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == 4'd14) |=> flags_o == $past(bus_i));

    // R12
    unknown_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == 4'd15) |=> flags_o == ($past(flags_o) & 8'hDF));

endmodule

bind psr_unit psr_unit_chk u_chk (.*);

// File: tb/psr_unit_tb.sv
module psr_unit_tb;

    typedef struct packed {
        logic [7:0] pre;
        logic [3:0] cls;
        logic [3:0] nvzc;
        logic [7:0] bus;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{8'h3C, 4'd1,  4'b1111, 8'hA5, 8'hDF, 8'd5},  // R5
        '{8'hC3, 4'd1,  4'b0000, 8'hA5, 8'h00, 8'd5},  // R5
        '{8'h01, 4'd2,  4'b1110, 8'hA5, 8'hC3, 8'd6},  // R6
        '{8'h20, 4'd2,  4'b0101, 8'hA5, 8'h40, 8'd6},  // R6
        '{8'hC0, 4'd3,  4'b1011, 8'hA5, 8'h43, 8'd7},  // R7
        '{8'h40, 4'd4,  4'b1001, 8'hA5, 8'hC1, 8'd8},  // R8
        '{8'h25, 4'd5,  4'b1011, 8'hA5, 8'h87, 8'd9},  // R9
        '{8'hFF, 4'd6,  4'b1111, 8'hA5, 8'hDE, 8'd10}, // R10 clear C
        '{8'h00, 4'd7,  4'b0000, 8'hA5, 8'h01, 8'd10}, // R10 set C
        '{8'hFF, 4'd8,  4'b1111, 8'hA5, 8'hD7, 8'd10}, // R10 clear D
        '{8'h00, 4'd9,  4'b0000, 8'hA5, 8'h08, 8'd10}, // R10 set D
        '{8'hFF, 4'd10, 4'b1111, 8'hA5, 8'hDB, 8'd10}, // R10 clear I
        '{8'h00, 4'd11, 4'b0000, 8'hA5, 8'h04, 8'd10}, // R10 set I
        '{8'hFF, 4'd12, 4'b1111, 8'hA5, 8'h9F, 8'd10}, // R10 clear V
        '{8'h81, 4'd13, 4'b0000, 8'hA5, 8'hA1, 8'd4},  // R4
        '{8'h00, 4'd14, 4'b1111, 8'h5A, 8'h5A, 8'd11}, // R11
        '{8'hFF, 4'd15, 4'b0000, 8'hA5, 8'hDF, 8'd12}, // R12
        '{8'hFF, 4'd0,  4'b0000, 8'hA5, 8'hDF, 8'd3}   // R3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_i = 1'b0;
    logic [3:0] cls_i = 4'd0;
    logic [3:0] alu_nvzc_i = 4'd0;
    logic [7:0] bus_i = 8'd0;
    logic [7:0] flags_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    psr_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done_i),
        .cls_i      (cls_i),
        .alu_nvzc_i (alu_nvzc_i),
        .bus_i      (bus_i),
        .flags_o    (flags_o)
    );

    task automatic step(input logic d, input logic [3:0] c,
                        input logic [3:0] a, input logic [7:0] b);
        @(negedge clk);
        done_i = d; cls_i = c; alu_nvzc_i = a; bus_i = b;
        @(posedge clk);
        @(negedge clk);
        done_i = 1'b0;
    endtask

    task automatic check(input string tag, input logic [7:0] exp);
        checks++;
        if (flags_o !== exp) begin
            errors++;
            $display("FAIL %s: flags_o=%h expected=%h", tag, flags_o, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset value
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 8'h04);
        rst_n = 1'b1;

        // Table walk: preset with a full load, then apply the vector
        for (int i = 0; i < NVEC; i++) begin
            step(1'b1, 4'd14, 4'b0000, VECS[i].pre);
            step(1'b1, VECS[i].cls, VECS[i].nvzc, VECS[i].bus);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
        end

        // R2: idle cycles hold the value under busy inputs
        step(1'b1, 4'd14, 4'b0000, 8'h3C);
        step(1'b0, 4'd1, 4'b1111, 8'hFF);
        check("R2 idle arith", 8'h3C);
        step(1'b0, 4'd14, 4'b0000, 8'h00);
        check("R2 idle load", 8'h3C);
        step(1'b0, 4'd13, 4'b1111, 8'hFF);
        check("R2 idle setT", 8'h3C);

        // R4 then R3: T set, then cleared by the next completion
        step(1'b1, 4'd13, 4'b0000, 8'h00);
        check("R4 setT", 8'h3C);
        step(1'b1, 4'd5, 4'b0000, 8'h00);
        check("R3 T cleared after NZ", 8'h1C);

        // R11: load of all ones including T
        step(1'b1, 4'd14, 4'b0000, 8'hFF);
        check("R11 load all ones", 8'hFF);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        done_i = 1'b1; cls_i = 4'd14; bus_i = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid-run", 8'h04);
        done_i = 1'b0;
        rst_n = 1'b1;
        step(1'b0, 4'd0, 4'b0000, 8'h00);
        check("R1 held after reset", 8'h04);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule